// File: doc/BRIEF.md
# Host Bus Register-Select Front End

This block sits between a CPU-style parallel bus and the register file of a UART. The bus brings a 3-bit register address, three chip-select lines of mixed polarity, an active-low address strobe and separate read and write strobes. The block gives the register file a registered address, a registered device-select flag and single-cycle read and write pulses. On the bus side it drives an output-enable for the data lines and an active-low driver-disable that an external transceiver uses to learn the bus direction. The tristate pins are outside the block. The data bus is therefore split into an inbound bus, an outbound bus and an enable.

While the address strobe is low, the address and chip-select lines pass straight through to the select logic. When the strobe goes high, the block freezes the levels it saw in the last cycle the strobe was low. It keeps them until the strobe goes low again. This lets a multiplexed bus drop its address early. All inputs are sampled in the system clock domain. The reset is asserted asynchronously, active low, and released on a clock edge.

Top module: `uart_bus_front`

## Requirements
- R1: `reg_addr_o` and `reg_sel_o` are registered: they show the effective address and select one clock after the inputs that produced them.
- R2: While `strobe_n_i` is 0, the effective address and chip selects are the live input levels, so an input change shows at the outputs one clock later.
- R3: While `strobe_n_i` is 1, the effective address and chip selects keep the values sampled in the last clock the strobe was 0. Input changes made while the strobe is high have no effect on `reg_addr_o` or `reg_sel_o`.
- R4: The device is selected only when `cs0_i`=1, `cs1_i`=1 and `cs2_i`=0. Under any other combination there is no read pulse, no write pulse and no output enable.
- R5: In the clock after a cycle where `rd_i` is 1, `wr_i` is 0 and the device is selected, `doe_o` is 1. Otherwise it is 0. `dout_o` equals `reg_rdata_i` while `doe_o` is 1 and is 0 otherwise.
- R6: `drv_dis_n_o` is always the inverse of `doe_o`.
- R7: A 0-to-1 change of `wr_i` while the device is selected gives a `reg_wr_o` pulse exactly one clock long. `reg_wdata_o` carries the `din_i` sampled in that cycle and holds it until the next write.
- R8: When `rd_i` and `wr_i` are both 1, the write takes priority: a write pulse may issue, no read pulse issues and `doe_o` stays 0.
- R9: During and right after reset, `reg_addr_o`=0, `reg_sel_o`=0, both pulses are 0, `doe_o`=0 and `drv_dis_n_o`=1.
- R10: A 0-to-1 change of `rd_i` while the device is selected gives a `reg_rd_o` pulse exactly one clock long. Holding `rd_i` high gives no further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address from the bus |
| cs0_i | input | 1 | Chip select, active high |
| cs1_i | input | 1 | Chip select, active high |
| cs2_i | input | 1 | Chip select, active low |
| strobe_n_i | input | 1 | Address strobe, active low |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| din_i | input | 8 | Inbound data from the bus pins |
| reg_rdata_i | input | 8 | Read data from the register file |
| reg_addr_o | output | 3 | Registered register address |
| reg_sel_o | output | 1 | Registered device-select flag |
| reg_rd_o | output | 1 | Single-cycle read pulse |
| reg_wr_o | output | 1 | Single-cycle write pulse |
| reg_wdata_o | output | 8 | Write data captured with the pulse |
| dout_o | output | 8 | Outbound data to the bus pins |
| doe_o | output | 1 | Output enable for the data pins |
| drv_dis_n_o | output | 1 | Transceiver driver disable, low during reads |

## Verification
The bench changes the address and chip selects in the same cycle the strobe rises. A design that captures on the wrong side of the edge would then show the new values instead of the frozen ones. All eight chip-select combinations are tried with a read held active, so an inverted polarity or an OR-style decode shows up as a stray pulse or a stray enable. Read and write strobes are held for several cycles to catch level-driven pulses. A simultaneous read and write is applied, which a design without write priority would answer by driving the bus.

// File: rtl/uart_bus_pkg.sv
package uart_bus_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;

  // Classify one cycle's request; write wins when both strobes are high.
  function automatic acc_kind_e classify(input logic sel, input logic rd, input logic wr);
    if (!sel)    return ACC_IDLE;
    else if (wr) return ACC_WR;
    else if (rd) return ACC_RD;
    else         return ACC_IDLE;
  endfunction

endpackage

// File: rtl/bus_latch.sv
module bus_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_n,
  input  logic [W-1:0] live,
  output logic [W-1:0] eff
);

  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic         hold_en;

  // Track the inputs while the strobe is low; freeze once it is high.
  always_comb begin
    hold_en = ~strobe_n;
    hold_d  = hold_q;
    if (hold_en) hold_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign eff = strobe_n ? hold_q : live;

endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int          N   = 3,
  parameter logic [N-1:0] POL = 3'b011
) (
  input  logic [N-1:0] cs,
  output logic         sel
);

  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (POL[i]) begin : g_hi
      assign match[i] = cs[i];
    end else begin : g_lo
      assign match[i] = ~cs[i];
    end
  end

  assign sel = &match;

endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
  import uart_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic          rd_pulse,
  output logic          wr_pulse,
  output logic [DW-1:0] wdata,
  output logic          doe,
  output logic          drv_dis_n
);

  logic          rd_q, wr_q;
  logic          rd_pulse_d, wr_pulse_d, doe_d;
  logic [DW-1:0] wdata_d;
  acc_kind_e     kind;

  always_comb begin
    kind       = classify(sel, rd, wr);
    wr_pulse_d = (kind == ACC_WR) && !wr_q;
    rd_pulse_d = (kind == ACC_RD) && !rd_q;
    doe_d      = (kind == ACC_RD);
    wdata_d    = wdata;
    if (wr_pulse_d) wdata_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rd_pulse  <= 1'b0;
      wr_pulse  <= 1'b0;
      wdata     <= '0;
      doe       <= 1'b0;
      drv_dis_n <= 1'b1;
    end else begin
      rd_q      <= rd;
      wr_q      <= wr;
      rd_pulse  <= rd_pulse_d;
      wr_pulse  <= wr_pulse_d;
      wdata     <= wdata_d;
      doe       <= doe_d;
      drv_dis_n <= ~doe_d;
    end
  end

endmodule

// File: rtl/uart_bus_front.sv
module uart_bus_front #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          cs0_i,
  input  logic          cs1_i,
  input  logic          cs2_i,
  input  logic          strobe_n_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_sel_o,
  output logic          reg_rd_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [DW-1:0] dout_o,
  output logic          doe_o,
  output logic          drv_dis_n_o
);

  localparam int           NCS   = 3;
  localparam logic [NCS-1:0] CSPOL = 3'b011;
  localparam int           LW    = AW + NCS;

  // Reset: asserted at once, released on a clock edge.
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [LW-1:0]  live_sel, eff_sel;
  logic [AW-1:0]  eff_addr;
  logic [NCS-1:0] eff_cs;
  logic           dev_sel;

  assign live_sel = {cs2_i, cs1_i, cs0_i, addr_i};

  bus_latch #(.W(LW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_s2),
    .strobe_n (strobe_n_i),
    .live     (live_sel),
    .eff      (eff_sel)
  );

  assign eff_addr = eff_sel[AW-1:0];
  assign eff_cs   = eff_sel[LW-1:AW];

  cs_decode #(.N(NCS), .POL(CSPOL)) u_dec (
    .cs  (eff_cs),
    .sel (dev_sel)
  );

  logic [AW-1:0] addr_d;
  logic          sel_d;
  always_comb begin
    addr_d = eff_addr;
    sel_d  = dev_sel;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      reg_addr_o <= '0;
      reg_sel_o  <= 1'b0;
    end else begin
      reg_addr_o <= addr_d;
      reg_sel_o  <= sel_d;
    end
  end

  access_ctrl #(.DW(DW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_s2),
    .sel       (dev_sel),
    .rd        (rd_i),
    .wr        (wr_i),
    .din       (din_i),
    .rd_pulse  (reg_rd_o),
    .wr_pulse  (reg_wr_o),
    .wdata     (reg_wdata_o),
    .doe       (doe_o),
    .drv_dis_n (drv_dis_n_o)
  );

  assign dout_o = doe_o ? reg_rdata_i : '0;

endmodule

// File: rtl/uart_bus_front_chk.sv
module uart_bus_front_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_n_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] reg_addr_o,
  input logic          reg_sel_o,
  input logic          reg_rd_o,
  input logic          reg_wr_o,
  input logic          doe_o,
  input logic          drv_dis_n_o
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(strobe_n_i) && $past(strobe_n_i, 2))
      |-> ($stable(reg_addr_o) && $stable(reg_sel_o)));

  assert_wr_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o || reg_rd_o || doe_o) |-> reg_sel_o);

  assert_wr_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  assert_rd_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);

  assert_doe_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && doe_o) |-> ($past(rd_i) && !$past(wr_i)));

  assert_wr_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  always @(negedge clk) begin
    if (rst_n) begin
      assert_dis_inverse_R6: assert (drv_dis_n_o == !doe_o);
    end
  end

endmodule

bind uart_bus_front uart_bus_front_chk #(.AW(AW)) chk_i (.*);

// File: tb/uart_bus_front_tb_top.sv
module uart_bus_front_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr_i;
  logic       cs0_i, cs1_i, cs2_i, strobe_n_i, rd_i, wr_i;
  logic [7:0] din_i, reg_rdata_i;
  logic [2:0] reg_addr_o;
  logic       reg_sel_o, reg_rd_o, reg_wr_o, doe_o, drv_dis_n_o;
  logic [7:0] reg_wdata_o, dout_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  uart_bus_front dut_i (.*);

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pick(input logic on);
    cs0_i = on; cs1_i = on; cs2_i = !on;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr_i = 3'd0; pick(1'b0); strobe_n_i = 1'b1;
    rd_i = 1'b0; wr_i = 1'b0; din_i = 8'h00; reg_rdata_i = 8'h00;
    repeat (3) tick();
    chk("R9", "doe", doe_o, 0);
    chk("R9", "drv_dis_n", drv_dis_n_o, 1);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R9", "sel", reg_sel_o, 0);
    chk("R9", "addr", reg_addr_o, 0);
    chk("R9", "pulses", {reg_rd_o, reg_wr_o}, 0);
  endtask

  task automatic t_transparent();
    strobe_n_i = 1'b0; pick(1'b1); addr_i = 3'd5;
    tick();
    chk("R2", "addr live", reg_addr_o, 5);
    chk("R1", "sel live", reg_sel_o, 1);
    addr_i = 3'd2;
    tick();
    chk("R2", "addr follows", reg_addr_o, 2);
  endtask

  task automatic t_hold();
    addr_i = 3'd3; pick(1'b1); strobe_n_i = 1'b0;
    tick();
    strobe_n_i = 1'b1; addr_i = 3'd6; pick(1'b0);
    tick();
    chk("R3", "addr frozen", reg_addr_o, 3);
    chk("R3", "sel frozen", reg_sel_o, 1);
    addr_i = 3'd7;
    tick();
    chk("R3", "addr still frozen", reg_addr_o, 3);
    strobe_n_i = 1'b0;
    tick();
    chk("R2", "addr after release", reg_addr_o, 7);
    chk("R4", "sel after release", reg_sel_o, 0);
  endtask

  task automatic t_decode();
    strobe_n_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      logic exp;
      {cs2_i, cs1_i, cs0_i} = c[2:0];
      addr_i = c[2:0];
      exp = (c == 3);
      rd_i = 1'b1;
      tick();
      chk("R4", $sformatf("rd pulse cs=%0d", c), reg_rd_o, exp);
      chk("R4", $sformatf("doe cs=%0d", c), doe_o, exp);
      rd_i = 1'b0;
      tick();
    end
  endtask

  task automatic t_read();
    strobe_n_i = 1'b0; pick(1'b1); addr_i = 3'd1; reg_rdata_i = 8'hA5;
    tick();
    rd_i = 1'b1;
    tick();
    chk("R10", "rd pulse", reg_rd_o, 1);
    chk("R5", "doe", doe_o, 1);
    chk("R5", "dout", dout_o, 8'hA5);
    chk("R6", "drv_dis_n low", drv_dis_n_o, 0);
    tick();
    chk("R10", "no second pulse", reg_rd_o, 0);
    chk("R5", "doe held", doe_o, 1);
    tick();
    chk("R10", "still no pulse", reg_rd_o, 0);
    rd_i = 1'b0;
    tick();
    chk("R5", "doe off", doe_o, 0);
    chk("R5", "dout zero", dout_o, 0);
    chk("R6", "drv_dis_n high", drv_dis_n_o, 1);
  endtask

  task automatic t_write();
    strobe_n_i = 1'b0; pick(1'b1); addr_i = 3'd4; din_i = 8'h3C;
    wr_i = 1'b1;
    tick();
    chk("R7", "wr pulse", reg_wr_o, 1);
    chk("R7", "wdata", reg_wdata_o, 8'h3C);
    chk("R7", "addr with write", reg_addr_o, 4);
    chk("R5", "no doe on write", doe_o, 0);
    din_i = 8'h77;
    tick();
    chk("R7", "wr pulse ends", reg_wr_o, 0);
    chk("R7", "wdata held", reg_wdata_o, 8'h3C);
    wr_i = 1'b0;
    tick();
  endtask

  task automatic t_both();
    strobe_n_i = 1'b0; pick(1'b1); din_i = 8'h5A;
    rd_i = 1'b1; wr_i = 1'b1;
    tick();
    chk("R8", "wr wins", reg_wr_o, 1);
    chk("R8", "no rd", reg_rd_o, 0);
    chk("R8", "no doe", doe_o, 0);
    chk("R6", "drv_dis_n high", drv_dis_n_o, 1);
    tick();
    chk("R8", "no doe held", doe_o, 0);
    rd_i = 1'b0; wr_i = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_decode();
    t_read();
    t_write();
    t_both();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

endmodule